// File: doc/BRIEF.md
# Classed Instruction Queue Dispatcher

This block sits behind a sequencer's decode stage and takes at most one decoded instruction per clock. Each instruction carries a two-bit class tag. Prefetch, playback and load/store instructions each go into their own FIFO. This lets the sequencer run ahead of real time and get past short events, such as a very brief waveform. Prefetch entries leave as soon as they reach the head of their FIFO. Playback and load/store entries leave only when an external timing strobe allows them.

A value-returning ("get") instruction cannot be queued, because later instructions may depend on its result. When one arrives, the block holds the sequencer in a stall until all three FIFOs have drained. It then completes the get with a one-cycle pulse that carries a 32-bit value taken from an input port. A full target FIFO also stalls the sequencer, and the entry is held at the input rather than dropped.

Top module: `instr_class_dispatch`

## Requirements
- R1: After reset, `stall`, `pb_valid`, `pf_valid`, `ls_valid` and `get_valid` are all low.
- R2: An instruction is accepted on a rising edge where `in_valid` is high and `stall` is low, one per cycle at most. The class code decides the route: 0 = playback, 1 = prefetch, 2 = load/store, 3 = get.
- R3: A prefetch entry is released without any strobe. When its FIFO was empty at acceptance, `pf_valid` rises one cycle after the accepting edge.
- R4: A load/store entry is released only on an edge where `tick` is high, one entry per such edge. `ls_valid` is high in the following cycle.
- R5: A playback entry is released only on a `tick` edge, and only when no earlier playback is still running. A playback counts as running from its release until an edge with `play_done` high. A `tick` and a `play_done` on the same edge allow the next release on that edge.
- R6: A get holds `stall` high until all three FIFOs are empty. It then raises `get_valid` for exactly one cycle, with `get_data` equal to `get_value` sampled on the completing edge.
- R7: While a get is pending, `stall` stays high and no instruction of any class is accepted. Instructions offered during that time are accepted only after `get_valid`.
- R8: When the FIFO for an offered non-get instruction holds DEPTH entries, `stall` is high and the instruction is held, not lost. It is accepted once a slot frees.
- R9: Each FIFO releases its entries in the order they were accepted, with the payload unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_class | input | 2 | Class code (0 playback, 1 prefetch, 2 load/store, 3 get) |
| in_data | input | DW | Instruction payload |
| tick | input | 1 | Timing strobe for playback and load/store release |
| play_done | input | 1 | Current waveform playback finished |
| get_value | input | RW | Value returned when a get completes |
| stall | output | 1 | Sequencer must hold the offered instruction |
| pb_valid | output | 1 | Playback command released |
| pb_data | output | DW | Playback command payload |
| pf_valid | output | 1 | Prefetch command released |
| pf_data | output | DW | Prefetch command payload |
| ls_valid | output | 1 | Load/store command released |
| ls_data | output | DW | Load/store command payload |
| get_valid | output | 1 | Get completed (one-cycle pulse) |
| get_data | output | RW | Value returned by the get |

## Verification
Two events can meet on one edge: the end of a running playback (`play_done`) and a timing strobe that wants to release the next playback entry. The bench arranges this by first showing that a strobe without `play_done` releases nothing. It then drives both signals high in the same cycle and expects the queued playback command in the very next cycle, with no strobe lost. A second meeting point is a pending get and the draining of a load/store entry. Here the bench expects the get to complete in the cycle right after the queue empties, and a load/store offered during the wait to be accepted only after that.

// File: rtl/instr_class_dispatch.sv
module instr_class_dispatch #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int RW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_class,
  input  logic [DW-1:0] in_data,
  input  logic          tick,
  input  logic          play_done,
  input  logic [RW-1:0] get_value,
  output logic          stall,
  output logic          pb_valid,
  output logic [DW-1:0] pb_data,
  output logic          pf_valid,
  output logic [DW-1:0] pf_data,
  output logic          ls_valid,
  output logic [DW-1:0] ls_data,
  output logic          get_valid,
  output logic [RW-1:0] get_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] C_PB = 2'd0, C_PF = 2'd1, C_LS = 2'd2, C_GET = 2'd3;

  logic [3:0]    full;
  logic [2:0]    empty, push, pop;
  logic [DW-1:0] head [3];
  logic          get_busy, play_busy;

  wire is_get = (in_class == C_GET);
  assign full[3] = 1'b0;
  assign stall = get_busy | (in_valid & ~is_get & full[in_class]);
  wire take = in_valid & ~stall;

  assign pop[C_PF] = ~empty[C_PF];
  assign pop[C_LS] = tick & ~empty[C_LS];
  assign pop[C_PB] = tick & ~empty[C_PB] & (~play_busy | play_done);

  for (genvar q = 0; q < 3; q++) begin : g_q
    localparam logic [1:0] QC = 2'(q);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd, wr;
    logic [CW-1:0] cnt;

    assign push[q]  = take & (in_class == QC);
    assign full[q]  = (cnt == CW'(DEPTH));
    assign empty[q] = (cnt == '0);
    assign head[q]  = mem[rd];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd  <= '0;
        wr  <= '0;
        cnt <= '0;
      end else begin
        if (push[q]) begin
          mem[wr] <= in_data;
          wr <= (wr == AW'(DEPTH - 1)) ? '0 : wr + 1'b1;
        end
        if (pop[q]) rd <= (rd == AW'(DEPTH - 1)) ? '0 : rd + 1'b1;
        cnt <= cnt + CW'(push[q]) - CW'(pop[q]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_valid  <= 1'b0;
      pf_valid  <= 1'b0;
      ls_valid  <= 1'b0;
      get_valid <= 1'b0;
      get_busy  <= 1'b0;
      play_busy <= 1'b0;
      pb_data   <= '0;
      pf_data   <= '0;
      ls_data   <= '0;
      get_data  <= '0;
    end else begin
      pb_valid  <= pop[C_PB];
      pf_valid  <= pop[C_PF];
      ls_valid  <= pop[C_LS];
      get_valid <= 1'b0;
      if (pop[C_PB]) pb_data <= head[C_PB];
      if (pop[C_PF]) pf_data <= head[C_PF];
      if (pop[C_LS]) ls_data <= head[C_LS];
      if (pop[C_PB])     play_busy <= 1'b1;
      else if (play_done) play_busy <= 1'b0;
      if (take & is_get) get_busy <= 1'b1;
      else if (get_busy & (&empty)) begin
        get_busy  <= 1'b0;
        get_valid <= 1'b1;
        get_data  <= get_value;
      end
    end
  end
endmodule

// File: rtl/dispatch_chk.sv
module dispatch_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic play_done,
  input logic stall,
  input logic pb_valid,
  input logic ls_valid,
  input logic get_valid,
  input logic get_busy
);
  AST_LS_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ls_valid |-> $past(tick)); // R4
  AST_PB_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pb_valid |-> $past(tick)); // R5
  AST_PB_WAITS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_valid && !play_done) |=> !pb_valid); // R5
  AST_GET_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    get_valid |=> !get_valid); // R6
  AST_GET_HOLDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    get_busy |-> stall); // R7
endmodule

bind instr_class_dispatch dispatch_chk u_chk (.*);

// File: tb/sim_instr_class_dispatch.sv
module sim_instr_class_dispatch;
  localparam int DW = 16, DEPTH = 8, RW = 32;
  logic clk = 0, rst_n = 0, in_valid = 0, tick = 0, play_done = 0;
  logic [1:0] in_class = 0;
  logic [DW-1:0] in_data = 0;
  logic [RW-1:0] get_value = 0;
  logic stall, pb_valid, pf_valid, ls_valid, get_valid;
  logic [DW-1:0] pb_data, pf_data, ls_data;
  logic [RW-1:0] get_data;

  instr_class_dispatch #(.DW(DW), .DEPTH(DEPTH), .RW(RW)) u0 (.*);

  always #5 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0, acc_cyc = 0;
  int pb_n = 0, pf_n = 0, ls_n = 0, get_n = 0;
  logic [DW-1:0] pb_log [64], pf_log [64], ls_log [64];
  int pf_cyc [64];
  logic [RW-1:0] get_log [8];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n) begin
    if (pb_valid)  begin pb_log[pb_n] = pb_data; pb_n++; end
    if (pf_valid)  begin pf_log[pf_n] = pf_data; pf_cyc[pf_n] = cyc; pf_n++; end
    if (ls_valid)  begin ls_log[ls_n] = ls_data; ls_n++; end
    if (get_valid) begin get_log[get_n] = get_data; get_n++; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] c, input logic [DW-1:0] d);
    @(negedge clk); in_valid = 1; in_class = c; in_data = d;
    #1; while (stall) begin @(negedge clk); #1; end
    @(posedge clk); #1; acc_cyc = cyc; in_valid = 0;
  endtask

  task automatic pulse(input bit done_too);
    @(negedge clk); tick = 1; play_done = done_too;
    @(negedge clk); tick = 0; play_done = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!stall && !pb_valid && !pf_valid && !ls_valid && !get_valid, "R1 reset outputs",
        {stall, pb_valid, pf_valid, ls_valid, get_valid}, 0);
  endtask

  task automatic t_prefetch;
    int b = pf_n;
    int a0;
    send(2'd1, 16'h0A11); a0 = acc_cyc;
    send(2'd1, 16'h0A12);
    send(2'd1, 16'h0A13);
    idle(3);
    chk(pf_n - b == 3, "R3 prefetch count without tick", pf_n - b, 3);
    chk(pf_cyc[b] == a0 + 1, "R3 prefetch latency", pf_cyc[b], a0 + 1);
    chk(pf_log[b] == 16'h0A11 && pf_log[b+1] == 16'h0A12 && pf_log[b+2] == 16'h0A13,
        "R9 prefetch order", pf_log[b+2], 16'h0A13);
  endtask

  task automatic t_loadstore;
    int b = ls_n;
    send(2'd2, 16'h0B01); send(2'd2, 16'h0B02); send(2'd2, 16'h0B03);
    idle(5);
    chk(ls_n == b, "R4 no load/store release without tick", ls_n - b, 0);
    pulse(0); idle(1);
    chk(ls_n - b == 1, "R4 one entry per tick", ls_n - b, 1);
    pulse(0); pulse(0); idle(2);
    chk(ls_n - b == 3, "R4 all released after three ticks", ls_n - b, 3);
    chk(ls_log[b] == 16'h0B01 && ls_log[b+1] == 16'h0B02 && ls_log[b+2] == 16'h0B03,
        "R9 load/store order", ls_log[b+1], 16'h0B02);
  endtask

  task automatic t_playback;
    int b = pb_n;
    send(2'd0, 16'h0C01); send(2'd0, 16'h0C02);
    idle(3);
    chk(pb_n == b, "R5 no playback release without tick", pb_n - b, 0);
    pulse(0); idle(1);
    chk(pb_n - b == 1 && pb_log[b] == 16'h0C01, "R5 first playback on tick", pb_log[b], 16'h0C01);
    pulse(0); idle(2);
    chk(pb_n - b == 1, "R5 tick while playing releases nothing", pb_n - b, 1);
    pulse(1); idle(1);
    chk(pb_n - b == 2 && pb_log[b+1] == 16'h0C02, "R5 tick with play_done same cycle",
        pb_n - b, 2);
    pulse(0); pulse(1); idle(1);
  endtask

  task automatic t_get;
    int lb = ls_n, gb = get_n;
    bit ok_stall = 1;
    get_value = 32'hCAFE0001;
    send(2'd2, 16'h0D01);
    send(2'd3, 16'h0000);
    @(negedge clk); in_valid = 1; in_class = 2'd2; in_data = 16'h0D02;
    repeat (4) begin #1; if (!stall) ok_stall = 0; @(negedge clk); end
    chk(ok_stall, "R7 stall held while get pending", ok_stall, 1);
    chk(get_n == gb, "R6 get waits for queue drain", get_n - gb, 0);
    chk(ls_n == lb, "R7 nothing released or taken", ls_n - lb, 0);
    tick = 1; @(negedge clk); tick = 0;
    #1; while (stall) begin @(negedge clk); #1; end
    @(posedge clk); #1; in_valid = 0;
    get_value = 32'h0;
    idle(1);
    chk(get_n - gb == 1, "R6 single get pulse", get_n - gb, 1);
    chk(get_log[gb] == 32'hCAFE0001, "R6 get value", get_log[gb], 32'hCAFE0001);
    chk(ls_n - lb == 1 && ls_log[lb] == 16'h0D01, "R7 older entry drained first", ls_log[lb], 16'h0D01);
    pulse(0); idle(1);
    chk(ls_n - lb == 2 && ls_log[lb+1] == 16'h0D02, "R7 held entry taken after get",
        ls_log[lb+1], 16'h0D02);
  endtask

  task automatic t_full;
    int b = ls_n;
    bit ok_stall = 1;
    for (int i = 0; i < DEPTH; i++) send(2'd2, 16'h0E00 + 16'(i));
    @(negedge clk); in_valid = 1; in_class = 2'd2; in_data = 16'h0EFF;
    repeat (3) begin #1; if (!stall) ok_stall = 0; @(negedge clk); end
    chk(ok_stall, "R8 stall when target queue full", ok_stall, 1);
    tick = 1; @(negedge clk); tick = 0;
    #1; while (stall) begin @(negedge clk); #1; end
    @(posedge clk); #1; in_valid = 0;
    for (int i = 0; i < DEPTH; i++) pulse(0);
    idle(2);
    chk(ls_n - b == DEPTH + 1, "R8 no entry lost", ls_n - b, DEPTH + 1);
    for (int i = 0; i < DEPTH; i++)
      chk(ls_log[b+i] == 16'h0E00 + 16'(i), "R9 full queue order", ls_log[b+i], 16'h0E00 + i);
    chk(ls_log[b+DEPTH] == 16'h0EFF, "R8 held entry last", ls_log[b+DEPTH], 16'h0EFF);
  endtask

  task automatic t_mixed;
    int pb0 = pb_n, pf0 = pf_n, ls0 = ls_n;
    send(2'd2, 16'h0F02); send(2'd1, 16'h0F01); send(2'd0, 16'h0F00);
    idle(2);
    chk(pf_n - pf0 == 1 && pf_log[pf0] == 16'h0F01, "R2 class 1 routed to prefetch",
        pf_log[pf0], 16'h0F01);
    pulse(0); idle(1);
    chk(ls_n - ls0 == 1 && ls_log[ls0] == 16'h0F02, "R2 class 2 routed to load/store",
        ls_log[ls0], 16'h0F02);
    chk(pb_n - pb0 == 1 && pb_log[pb0] == 16'h0F00, "R2 class 0 routed to playback",
        pb_log[pb0], 16'h0F00);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_prefetch;
    t_loadstore;
    t_playback;
    t_get;
    t_full;
    t_mixed;
    idle(3);
    finish_run;
  end

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run;
  end
endmodule